// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the status and control word of a floating-point unit. The word carries mode bits and three 5-bit exception fields. The mode bits are the rounding code, denormal flushing, a precision select and a register-bank select. The three exception fields are the per-operation cause, the accumulated sticky flags and the trap enables. Software changes the word through a write port with a per-bit mask. Only bits that exist in the word take the written value, and every other bit always reads as zero.

When an arithmetic unit finishes an operation, it raises a completion strobe together with its five raw exception flags. On that strobe the block does three things:

- It throws away the previous cause field and loads the new flags into it.
- It folds the new cause into the sticky field by a fixed right shift.
- If any new cause bit has its enable bit set, it raises a one-cycle trap request that carries a fixed vector code.

A reciprocal square root that reports no flag at all is treated as inexact. The block also decodes the rounding code and the denormal bit into plain control lines for the arithmetic units.

Top module: `fpu_status_ctl`

## Requirements
- R1: After reset the word reads 0x0004_0001 (round-toward-zero code, denormal flush on), and `trapReq` is low.
- R2: A write updates exactly the bits whose `wrMask` bit is 1, and only among the writable bits. The writable bits are 1:0 (rounding), 6:2 (sticky), 11:7 (enable), 16:12 (cause), 18 (flush), 19 (precision) and 21 (bank). Bits 17, 20 and 31:22 always read zero.
- R3: `roundToZero` is 1 exactly when bits 1:0 hold 2'b01. The codes 00, 10 and 11 all give 0, which means round to nearest even.
- R4: `flushDenorm` follows bit 18 of the word.
- R5: `dblPrec` follows bit 19, and `bankSel` follows bit 21.
- R6: On `opDone`, the cause field (16:12) is cleared and replaced by the new flags. Each 5-bit field orders its bits from LSB as inexact, underflow, overflow, divide-by-zero, invalid.
- R7: On `opDone`, the new cause bits are ORed into the sticky field (6:2). An operation never clears a sticky bit.
- R8: When the new cause ANDed with the enable field is non-zero, `trapReq` pulses for one cycle together with the updated word, and `trapVec` reads 0x120 during the pulse. At all other times `trapReq` is 0 and `trapVec` is 0.
- R9: An operation with all flags zero clears the cause field, leaves the sticky field as it was and raises no trap.
- R10: On a reciprocal-square-root completion (`opIsRsqrt`=1) with all flags zero, the inexact flag is forced on. That forced flag counts toward the cause, the sticky field and the trap. A reciprocal square root that reports any flag uses its flags unchanged.
- R11: When a write and an operation completion fall in the same cycle, the write is applied first. The operation then rebuilds the cause field, and the trap decision uses the newly written enables.
- R12: With neither a write nor an operation, the word holds its value and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| wrMask | input | 32 | Per-bit write mask, 1 = update |
| opDone | input | 1 | Floating-point operation completed |
| opIsRsqrt | input | 1 | Completed operation is a reciprocal square root |
| opFlags | input | 5 | Raw exception flags of the completed operation |
| rdData | output | 32 | Current status and control word |
| roundToZero | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| flushDenorm | output | 1 | Flush denormals to zero |
| dblPrec | output | 1 | Precision select |
| bankSel | output | 1 | Register bank select |
| trapReq | output | 1 | One-cycle floating-point exception trap request |
| trapVec | output | 12 | Trap vector code while `trapReq` is high, otherwise zero |

## Verification
The bench builds the block with its default parameters: a reset word of 0x0004_0001 and trap code 0x120. With these defaults the reset state already exercises the round-toward-zero decode and the flush output before any write is made. Operations then run against several enable patterns. These cover trapping and non-trapping overlaps, the forced inexact case on reciprocal square root, and a write and a completion landing in the same cycle. A reference model in the bench predicts every word and trap pulse.

// File: rtl/fpu_status_pkg.sv
`timescale 1ns/1ps
package fpu_status_pkg;
  localparam int REG_W     = 32;
  localparam int EXC_N     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB = EN_LSB + EXC_N;
  localparam int DN_BIT    = 18;
  localparam int PREC_BIT  = 19;
  localparam int BANK_BIT  = 21;
  localparam int CAUSE_TO_FLAG = CAUSE_LSB - FLAG_LSB;

  // exception bit order inside each 5-bit field
  localparam int EXC_INEXACT   = 0;
  localparam int EXC_UNDERFLOW = 1;
  localparam int EXC_OVERFLOW  = 2;
  localparam int EXC_DIVZERO   = 3;
  localparam int EXC_INVALID   = 4;

  localparam logic [RM_W-1:0] RM_TO_ZERO = 2'b01;

  typedef struct packed {
    logic applyWrite;
    logic applyOp;
    logic forceInexact;
  } fsc_strobe_t;

  function automatic logic [REG_W-1:0] writableMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < RM_W; i++)  m[RM_LSB + i]    = 1'b1;
    for (int i = 0; i < EXC_N; i++) begin
      m[FLAG_LSB + i]  = 1'b1;
      m[EN_LSB + i]    = 1'b1;
      m[CAUSE_LSB + i] = 1'b1;
    end
    m[DN_BIT]   = 1'b1;
    m[PREC_BIT] = 1'b1;
    m[BANK_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpu_status_ctrl.sv
`timescale 1ns/1ps
module fpu_status_ctrl
  import fpu_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             opDone,
  input  logic             opIsRsqrt,
  input  logic [EXC_N-1:0] opFlags,
  input  logic             excHit,
  output fsc_strobe_t      strobe,
  output logic             trapReq
);
  logic noFlags;

  assign noFlags = (opFlags == '0);

  always_comb begin
    strobe              = '0;
    strobe.applyWrite   = wrEn;
    strobe.applyOp      = opDone;
    strobe.forceInexact = opDone & opIsRsqrt & noFlags;
  end

  // trap pulse registered alongside the status word
  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= strobe.applyOp & excHit;
  end
endmodule

// File: rtl/fpu_status_dp.sv
`timescale 1ns/1ps
module fpu_status_dp
  import fpu_status_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 32'h0004_0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsc_strobe_t      strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] wrMask,
  input  logic [EXC_N-1:0] opFlags,
  output logic [REG_W-1:0] statusQ,
  output logic             excHit
);
  localparam logic [REG_W-1:0] WMASK = writableMask();

  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] statusD;
  logic [REG_W-1:0] causeWord;
  logic [REG_W-1:0] causeShifted;
  logic [EXC_N-1:0] effFlags;
  logic [EXC_N-1:0] enables;

  // step 1: apply the masked write
  always_comb begin
    if (strobe.applyWrite)
      merged = ((statusQ & ~wrMask) | (wrData & wrMask)) & WMASK;
    else
      merged = statusQ;
  end

  // step 2: effective flags with forced inexact
  always_comb begin
    effFlags = opFlags;
    if (strobe.forceInexact) effFlags[EXC_INEXACT] = 1'b1;
  end

  assign enables = merged[EN_LSB +: EXC_N];

  // step 3: rebuild cause, fold into sticky by fixed shift
  always_comb begin
    causeWord = '0;
    causeWord[CAUSE_LSB +: EXC_N] = effFlags;
    causeShifted = causeWord >> CAUSE_TO_FLAG;
    statusD = merged;
    if (strobe.applyOp) begin
      statusD[CAUSE_LSB +: EXC_N] = effFlags;
      statusD[FLAG_LSB +: EXC_N]  = merged[FLAG_LSB +: EXC_N]
                                  | causeShifted[FLAG_LSB +: EXC_N];
    end
  end

  assign excHit = strobe.applyOp & (|(effFlags & enables));

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= RESET_VAL & WMASK;
    else       statusQ <= statusD;
  end
endmodule

// File: rtl/fpu_status_ctl.sv
`timescale 1ns/1ps
module fpu_status_ctl
  import fpu_status_pkg::*;
#(
  parameter int               TRAP_VEC_W = 12,
  parameter logic [TRAP_VEC_W-1:0] TRAP_VEC = 12'h120,
  parameter logic [31:0]      RESET_VAL  = 32'h0004_0001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [31:0]           wrData,
  input  logic [31:0]           wrMask,
  input  logic                  opDone,
  input  logic                  opIsRsqrt,
  input  logic [4:0]            opFlags,
  output logic [31:0]           rdData,
  output logic                  roundToZero,
  output logic                  flushDenorm,
  output logic                  dblPrec,
  output logic                  bankSel,
  output logic                  trapReq,
  output logic [TRAP_VEC_W-1:0] trapVec
);
  fsc_strobe_t      strobe;
  logic             excHit;
  logic [REG_W-1:0] statusQ;

  fpu_status_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .opDone    (opDone),
    .opIsRsqrt (opIsRsqrt),
    .opFlags   (opFlags),
    .excHit    (excHit),
    .strobe    (strobe),
    .trapReq   (trapReq)
  );

  fpu_status_dp #(.RESET_VAL(RESET_VAL)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .wrMask  (wrMask),
    .opFlags (opFlags),
    .statusQ (statusQ),
    .excHit  (excHit)
  );

  assign rdData      = statusQ;
  assign roundToZero = (statusQ[RM_LSB +: RM_W] == RM_TO_ZERO);
  assign flushDenorm = statusQ[DN_BIT];
  assign dblPrec     = statusQ[PREC_BIT];
  assign bankSel     = statusQ[BANK_BIT];
  assign trapVec     = trapReq ? TRAP_VEC : '0;
endmodule

// File: rtl/fpu_status_ctl_chk.sv
`timescale 1ns/1ps
module fpu_status_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        opDone,
  input logic        opIsRsqrt,
  input logic [4:0]  opFlags,
  input logic [31:0] rdData,
  input logic        roundToZero,
  input logic        flushDenorm,
  input logic        dblPrec,
  input logic        bankSel,
  input logic        trapReq,
  input logic [11:0] trapVec
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 32'hFFD2_0000) == 32'h0);
  // R3
  round_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundToZero == (rdData[1:0] == 2'b01));
  // R4
  flush_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDenorm == rdData[18]);
  // R5
  mode_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dblPrec == rdData[19]) && (bankSel == rdData[21]));
  // R6
  cause_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && !opIsRsqrt |=> rdData[16:12] == $past(opFlags));
  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && !wrEn |=> (rdData[6:2] & $past(rdData[6:2])) == $past(rdData[6:2]));
  // R7
  sticky_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && !opIsRsqrt |=> (rdData[6:2] & $past(opFlags)) == $past(opFlags));
  // R8
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (rdData[16:12] & rdData[11:7]) != 5'b0);
  // R8
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapVec == (trapReq ? 12'h120 : 12'h000));
  // R8
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opDone |=> !trapReq);
  // R9
  no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && !opIsRsqrt && (opFlags == 5'b0) |=> !trapReq && (rdData[16:12] == 5'b0));
  // R10
  rsqrt_inexact_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && opIsRsqrt && (opFlags == 5'b0) |=> rdData[16:12] == 5'b00001);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opDone && !wrEn |=> $stable(rdData) && !trapReq);
endmodule

bind fpu_status_ctl fpu_status_ctl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .opDone      (opDone),
  .opIsRsqrt   (opIsRsqrt),
  .opFlags     (opFlags),
  .rdData      (rdData),
  .roundToZero (roundToZero),
  .flushDenorm (flushDenorm),
  .dblPrec     (dblPrec),
  .bankSel     (bankSel),
  .trapReq     (trapReq),
  .trapVec     (trapVec)
);

// File: tb/fpu_status_ctl_tb.sv
`timescale 1ns/1ps
module fpu_status_ctl_tb;
  localparam logic [31:0] WMASK = 32'h002D_FFFF;

  typedef struct {
    logic [31:0] rd;
    logic        trap;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] wrMask = '0;
  logic        opDone = 1'b0;
  logic        opIsRsqrt = 1'b0;
  logic [4:0]  opFlags = '0;
  logic [31:0] rdData;
  logic        roundToZero, flushDenorm, dblPrec, bankSel, trapReq;
  logic [11:0] trapVec;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl = 32'h0004_0001;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fpu_status_ctl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrMask(wrMask),
    .opDone(opDone), .opIsRsqrt(opIsRsqrt), .opFlags(opFlags),
    .rdData(rdData), .roundToZero(roundToZero), .flushDenorm(flushDenorm),
    .dblPrec(dblPrec), .bankSel(bankSel), .trapReq(trapReq), .trapVec(trapVec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the predicted result
  task automatic step(string tag, logic we, logic [31:0] d, logic [31:0] m,
                      logic od, logic rs, logic [4:0] fl);
    logic [31:0] nxt;
    logic [4:0]  f;
    logic        tr;
    @(negedge clk);
    wrEn = we; wrData = d; wrMask = m;
    opDone = od; opIsRsqrt = rs; opFlags = fl;
    nxt = we ? (((mdl & ~m) | (d & m)) & WMASK) : mdl;
    tr = 1'b0;
    if (od) begin
      f = fl;
      if (rs && fl == 5'b0) f = 5'b00001;
      nxt[16:12] = f;
      nxt[6:2]   = nxt[6:2] | f;
      tr = |(f & nxt[11:7]);
    end
    mdl = nxt;
    q.push_back('{rd: nxt, trap: tr, tag: tag});
  endtask

  // monitor: compares one expected item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " word"}, rdData, e.rd);
        check({e.tag, " trap"}, {31'b0, trapReq}, {31'b0, e.trap});
        check({e.tag, " vec"}, {20'b0, trapVec}, e.trap ? 32'h120 : 32'h0);
        check({e.tag, " rtz"}, {31'b0, roundToZero}, {31'b0, (e.rd[1:0] == 2'b01)});
        check({e.tag, " modes"}, {29'b0, flushDenorm, dblPrec, bankSel},
              {29'b0, e.rd[18], e.rd[19], e.rd[21]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 reset word", rdData, 32'h0004_0001);
    check("R1 reset trap", {31'b0, trapReq}, 32'h0);
    check("R1 reset rtz", {31'b0, roundToZero}, 32'h1);
    check("R1 reset flush", {31'b0, flushDenorm}, 32'h1);

    step("R2 full write", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 5'h00);
    step("R2 partial mask", 1, 32'h0000_0000, 32'h0000_0F0F, 0, 0, 5'h00);
    step("R2 clear all", 1, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'h00);
    step("R3 code 00", 1, 32'h0, 32'h3, 0, 0, 5'h00);
    step("R3 code 01", 1, 32'h1, 32'h3, 0, 0, 5'h00);
    step("R3 code 10", 1, 32'h2, 32'h3, 0, 0, 5'h00);
    step("R3 code 11", 1, 32'h3, 32'h3, 0, 0, 5'h00);
    step("R4 flush on", 1, 32'h0004_0000, 32'h0004_0000, 0, 0, 5'h00);
    step("R5 bank prec", 1, 32'h0028_0000, 32'h0028_0000, 0, 0, 5'h00);
    step("R4 flush off", 1, 32'h0, 32'h0004_0000, 0, 0, 5'h00);
    step("R6 op flags", 0, 0, 0, 1, 0, 5'b10101);
    step("R7 sticky accumulates", 0, 0, 0, 1, 0, 5'b00010);
    step("R12 idle hold", 0, 0, 0, 0, 0, 5'h00);
    step("R8 enable invalid", 1, 32'h0000_0800, 32'h0000_0F80, 0, 0, 5'h00);
    step("R8 trap invalid", 0, 0, 0, 1, 0, 5'b10000);
    step("R8 pulse ends", 0, 0, 0, 0, 0, 5'h00);
    step("R8 no overlap", 0, 0, 0, 1, 0, 5'b00100);
    step("R9 zero flags", 0, 0, 0, 1, 0, 5'b00000);
    step("R10 rsqrt forced", 0, 0, 0, 1, 1, 5'b00000);
    step("R10 rsqrt flagged", 0, 0, 0, 1, 1, 5'b01000);
    step("R10 enable inexact", 1, 32'h0000_0080, 32'h0000_0F80, 0, 0, 5'h00);
    step("R10 rsqrt trap", 0, 0, 0, 1, 1, 5'b00000);
    step("R2 clear sticky", 1, 32'h0, 32'h0000_007C, 0, 0, 5'h00);
    step("R11 write with op", 1, 32'h0000_0200, 32'h0000_0F80, 1, 0, 5'b00100);
    step("R11 write cause then op", 1, 32'h0001_F000, 32'h0001_F000, 1, 0, 5'b00001);
    step("R12 idle after", 0, 0, 0, 0, 0, 5'h00);
    step("R12 idle again", 0, 0, 0, 0, 0, 5'h00);
    while (q.size() > 0) @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule